// File: doc/BRIEF.md
# Double-Buffered Byte-Programmed PWM Generator

This block produces a pulse-width modulated output whose period and high time are each 16-bit values, loaded by software one byte at a time through a small register port. A 2-bit select picks one of four byte registers: period low byte (0), period high byte (1), high-time low byte (2) and high-time high byte (3). Every byte written is kept in a staging register and can be read back at once. The staged values have no effect on the output until the high-time high byte is written. That write commits all four staged bytes together, so the counter can never run with half of an old value and half of a new one.

A committed pair is not applied at once. It waits for the end of the PWM cycle in progress, so no cycle is cut short or stretched. The counter advances only on cycles where the clock enable is high. Each cycle runs through P counts, where P is the period value, and values 0 and 1 are raised to 2. The output is high for the first D counts of each cycle, where D is the high-time value. D = 0 gives a constant low and D >= P gives a constant high.

Top module: `dbl_buf_pwm`

## Requirements
- R1: After a synchronous active-low reset, all four byte registers read back 0x00, the output is low, and the running period is 2 with a high time of 0.
- R2: With the clock enable held high and a committed period P >= 2, the output repeats every P clock cycles, so a window of k*P cycles holds exactly k rising edges when 0 < D < P.
- R3: Within each cycle the output is high while the count, which runs from 0 to P-1, is below the committed high time D, so a window of k*P cycles holds exactly k*D high cycles.
- R4: A committed high time of 0 holds the output low on every cycle.
- R5: A committed high time equal to or greater than the committed period holds the output high on every cycle.
- R6: Writes to select codes 0, 1 and 2 alone leave the output waveform unchanged.
- R7: A write to select code 3 commits the staged period {code 1, code 0} and the staged high time {code 3, code 2} as one update.
- R8: A committed update takes effect only after the count wraps from P-1 to 0, so the cycle in progress completes with its old values.
- R9: Reading select code n returns the last byte written to code n. Data is read the cycle after the write.
- R10: A committed period of 0 or 1 runs as a period of 2.
- R11: While the clock enable is low, the count and the output hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Clock enable for the PWM counter |
| wr_en | input | 1 | Byte register write strobe |
| reg_sel | input | 2 | Byte register select (0 period lo, 1 period hi, 2 high-time lo, 3 high-time hi) |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read-back byte of the selected register |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest case to reach from the ports is a commit that lands in the middle of a long cycle, because the delay until it is applied depends on the counter's hidden phase. The bench first commits a 200-count period with a 100-count high time. It finds count zero by watching for a rising edge of the output. A few cycles later it commits a short period. The output must then stay high through the rest of the old high phase, and only later show the short cycle. Changes to the clock enable and writes that overlap a pending update are covered by a behavioural model, which is compared with the outputs on every clock.

// File: rtl/pwm_pkg.sv
// Package: shared constants and types for the double-buffered PWM.
// Assumes: included first in compile order.
package pwm_pkg;

    // Smallest period the counter will run with; smaller commits are raised to it.
    localparam int unsigned PWM_MIN_PERIOD = 2;

    // Whether a committed update is waiting for the next cycle boundary.
    typedef enum logic {
        SH_IDLE    = 1'b0,
        SH_PENDING = 1'b1
    } shadow_state_e;

endpackage

// File: rtl/pwm_stage_regs.sv
// Module: pwm_stage_regs
// Holds the byte-wide staging registers that software writes. It gives read-back
// of the selected byte and a one-cycle commit pulse after the highest high-time
// byte is written. The pulse arrives when the staged values already include that byte.
// Assumes: CNT_W is a multiple of DATA_W; lanes 0..NBYTE-1 form the period,
// lanes NBYTE..2*NBYTE-1 form the high time, the top lane triggers commit.
module pwm_stage_regs #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    parameter int NBYTE  = CNT_W / DATA_W,
    parameter int SEL_W  = $clog2(2 * NBYTE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  stage_per,
    output logic [CNT_W-1:0]  stage_duty,
    output logic              commit_p
);

    localparam int NLANE     = 2 * NBYTE;
    localparam int COMMIT_IX = NLANE - 1;

    logic [NLANE-1:0][DATA_W-1:0] lane_q;

    // Capture written bytes into the addressed staging lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            for (int i = 0; i < NLANE; i++) begin
                if (wr_en && (reg_sel == SEL_W'(i))) begin
                    lane_q[i] <= wr_data;
                end
            end
        end
    end

    // Raise commit for one cycle after the top high-time byte is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_p <= 1'b0;
        end else begin
            commit_p <= wr_en && (reg_sel == SEL_W'(COMMIT_IX));
        end
    end

    // Gather the lanes into the staged period and high-time words.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        if (g < NBYTE) begin : g_per
            assign stage_per[g*DATA_W +: DATA_W] = lane_q[g];
        end else begin : g_duty
            assign stage_duty[(g-NBYTE)*DATA_W +: DATA_W] = lane_q[g];
        end
    end

    // Read back the selected lane.
    always_comb begin
        rd_data = lane_q[reg_sel];
    end

endmodule

// File: rtl/pwm_shadow.sv
// Module: pwm_shadow
// Holds the active period and high time used by the counter. A commit is kept
// as pending and moved to the active set only on the counter's wrap cycle, or
// at once if the commit itself falls on the wrap cycle. A period below the
// minimum is raised to the minimum when it is captured.
// Assumes: commit_p is one cycle wide; wrap marks the last count of a cycle.
module pwm_shadow
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_p,
    input  logic             wrap,
    input  logic [CNT_W-1:0] stage_per,
    input  logic [CNT_W-1:0] stage_duty,
    output logic [CNT_W-1:0] act_per,
    output logic [CNT_W-1:0] act_duty
);

    localparam logic [CNT_W-1:0] MIN_P = CNT_W'(PWM_MIN_PERIOD);

    shadow_state_e    st_q;
    logic [CNT_W-1:0] pend_per_q;
    logic [CNT_W-1:0] pend_duty_q;
    logic [CNT_W-1:0] stage_per_cl;

    // Raise a too-small staged period to the minimum.
    always_comb begin
        stage_per_cl = (stage_per < MIN_P) ? MIN_P : stage_per;
    end

    // Keep the pending pair and move it to the active pair on a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= SH_IDLE;
            pend_per_q  <= MIN_P;
            pend_duty_q <= '0;
            act_per     <= MIN_P;
            act_duty    <= '0;
        end else if (commit_p) begin
            if (wrap) begin
                act_per  <= stage_per_cl;
                act_duty <= stage_duty;
                st_q     <= SH_IDLE;
            end else begin
                pend_per_q  <= stage_per_cl;
                pend_duty_q <= stage_duty;
                st_q        <= SH_PENDING;
            end
        end else if (wrap && (st_q == SH_PENDING)) begin
            act_per  <= pend_per_q;
            act_duty <= pend_duty_q;
            st_q     <= SH_IDLE;
        end
    end

endmodule

// File: rtl/pwm_counter.sv
// Module: pwm_counter
// Counter from 0 to act_per-1 that advances on enabled cycles. It flags the
// wrap cycle and forms the output by comparing the count with the high time.
// A high time of zero is forced low and one at or above the period is forced high.
// Assumes: act_per >= 2 and changes only on a wrap cycle.
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] act_per,
    input  logic [CNT_W-1:0] act_duty,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap,
    output logic             pwm_out
);

    logic at_last;
    logic duty_zero;
    logic duty_full;

    // Find the last count of the cycle and the two clamp conditions.
    always_comb begin
        at_last   = (cnt_q >= (act_per - CNT_W'(1)));
        wrap      = tick_en && at_last;
        duty_zero = (act_duty == '0);
        duty_full = (act_duty >= act_per);
    end

    // Advance the count on enabled cycles and return to zero after the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // Drive the output from the comparison, applying the clamps.
    always_comb begin
        pwm_out = !duty_zero && (duty_full || (cnt_q < act_duty));
    end

endmodule

// File: rtl/dbl_buf_pwm.sv
// Module: dbl_buf_pwm (top)
// PWM generator with double-buffered, byte-programmed period and high time.
// Staging registers take byte writes. A write to the top high-time byte commits
// both values, which the counter uses from the start of its next cycle.
// Assumes: bus decoding and clock generation are outside; tick_en sets the timebase.
module dbl_buf_pwm #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    parameter int SEL_W  = $clog2(2 * (CNT_W / DATA_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwm_out
);

    localparam int NBYTE = CNT_W / DATA_W;

    logic [CNT_W-1:0] stage_per;
    logic [CNT_W-1:0] stage_duty;
    logic             commit_p;
    logic [CNT_W-1:0] act_per;
    logic [CNT_W-1:0] act_duty;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    pwm_stage_regs #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .NBYTE  (NBYTE),
        .SEL_W  (SEL_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .reg_sel    (reg_sel),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .stage_per  (stage_per),
        .stage_duty (stage_duty),
        .commit_p   (commit_p)
    );

    pwm_shadow #(
        .CNT_W (CNT_W)
    ) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_p   (commit_p),
        .wrap       (wrap),
        .stage_per  (stage_per),
        .stage_duty (stage_duty),
        .act_per    (act_per),
        .act_duty   (act_duty)
    );

    pwm_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .act_per  (act_per),
        .act_duty (act_duty),
        .cnt_q    (cnt_q),
        .wrap     (wrap),
        .pwm_out  (pwm_out)
    );

endmodule

// File: rtl/dbl_buf_pwm_chk.sv
// Module: dbl_buf_pwm_chk
// Assertion checker bound into dbl_buf_pwm. It watches the ports together with
// the active values and count, which come from separate submodules.
module dbl_buf_pwm_chk #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    parameter int SEL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_en,
    input logic [SEL_W-1:0]  reg_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              pwm_out,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  act_per,
    input logic [CNT_W-1:0]  act_duty,
    input logic              wrap
);

    // R2: the count stays inside the running period
    a_r2_count_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < act_per);

    // R4: zero high time keeps the output low
    a_r4_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
        (act_duty == '0) |-> !pwm_out);

    // R5: high time at or above the period keeps the output high
    a_r5_full_duty_high: assert property (@(posedge clk) disable iff (!rst_n)
        (act_duty >= act_per) |-> pwm_out);

    // R8: the active values change only across a wrap
    a_r8_update_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(act_per) && $stable(act_duty)));

    // R9: a written byte reads back while the same select is held
    a_r9_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((reg_sel != $past(reg_sel)) || (rd_data == $past(wr_data))));

    // R10: the running period never drops below two
    a_r10_min_period: assert property (@(posedge clk) disable iff (!rst_n)
        act_per >= CNT_W'(2));

    // R11: with the enable low the count holds
    a_r11_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt_q));

endmodule

bind dbl_buf_pwm dbl_buf_pwm_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .SEL_W  (SEL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .wr_en    (wr_en),
    .reg_sel  (reg_sel),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .pwm_out  (pwm_out),
    .cnt_q    (cnt_q),
    .act_per  (act_per),
    .act_duty (act_duty),
    .wrap     (wrap)
);

// File: tb/dbl_buf_pwm_tb.sv
module dbl_buf_pwm_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    int en_mode = 0;
    logic [7:0] lfsr = 8'hA5;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // Behavioural reference state
    int m_stg[4];
    int m_per, m_duty, m_cnt;
    int m_pv, m_dv;
    bit m_pend;

    dbl_buf_pwm u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (wr_en),
        .reg_sel (reg_sel),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Enable pattern driver
    always @(posedge clk) begin
        #1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (en_mode)
            0: tick_en <= 1'b1;
            1: tick_en <= 1'b0;
            default: tick_en <= lfsr[0] | lfsr[2];
        endcase
    end

    // Reference model, updated on every clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_stg[i] = 0;
            m_per = 2; m_duty = 0; m_cnt = 0; m_pend = 0; m_pv = 2; m_dv = 0;
        end else begin
            if (tick_en) begin
                if (m_cnt >= m_per - 1) begin
                    m_cnt = 0;
                    if (m_pend) begin
                        m_per = m_pv; m_duty = m_dv; m_pend = 0;
                    end
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            if (wr_en) begin
                m_stg[reg_sel] = wr_data;
                if (reg_sel == 2'd3) begin
                    m_pv = m_stg[1] * 256 + m_stg[0];
                    if (m_pv < 2) m_pv = 2;
                    m_dv = m_stg[3] * 256 + m_stg[2];
                    m_pend = 1;
                end
            end
        end
    end

    // Compare with the model on every clock
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            bit e_out;
            e_out = (m_duty != 0) && ((m_duty >= m_per) || (m_cnt < m_duty));
            chk(pwm_out == e_out, "R2,R3,R8,R11 output vs model", pwm_out, e_out);
            chk(rd_data == m_stg[reg_sel], "R9 readback vs model", rd_data, m_stg[reg_sel]);
        end
    end

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; reg_sel = s; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic prog(input int p, input int d);
        wr(2'd0, p[7:0]); wr(2'd1, p[15:8]);
        wr(2'd2, d[7:0]); wr(2'd3, d[15:8]);
    endtask

    task automatic rd(input logic [1:0] s, output int v);
        @(posedge clk); #1;
        reg_sel = s;
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic measure(input int n, output int highs, output int rises);
        logic prev;
        @(negedge clk);
        prev = pwm_out;
        highs = 0; rises = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
            if (pwm_out && !prev) rises++;
            prev = pwm_out;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        int v, h, r;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int s = 0; s < 4; s++) begin
            rd(s[1:0], v);
            chk(v == 0, "R1 reset readback", v, 0);
        end
        measure(10, h, r);
        chk(h == 0, "R1 reset output low", h, 0);
        cmp_on = 1'b1;

        // R9: each byte reads back its own value
        wr(2'd0, 8'h12); wr(2'd1, 8'h34); wr(2'd2, 8'h56);
        rd(2'd0, v); chk(v == 8'h12, "R9 period lo", v, 8'h12);
        rd(2'd1, v); chk(v == 8'h34, "R9 period hi", v, 8'h34);
        rd(2'd2, v); chk(v == 8'h56, "R9 high-time lo", v, 8'h56);

        // R3 / R7: period 10, high time 3
        prog(10, 3);
        wait_cyc(30);
        measure(100, h, r);
        chk(h == 30, "R3 high count P10 D3", h, 30);
        chk(r == 10, "R2 rising edges P10", r, 10);

        // R6: staging writes without commit change nothing
        wr(2'd0, 8'd20); wr(2'd1, 8'd0); wr(2'd2, 8'd15);
        wait_cyc(30);
        measure(100, h, r);
        chk(h == 30, "R6 no commit keeps waveform", h, 30);
        rd(2'd0, v); chk(v == 20, "R9 staged period lo", v, 20);

        // R7: committing the top byte applies both staged values
        wr(2'd3, 8'd0);
        wait_cyc(40);
        measure(200, h, r);
        chk(h == 150, "R7 commit P20 D15 high count", h, 150);
        chk(r == 10, "R2 rising edges P20", r, 10);

        // R4: zero high time
        prog(20, 0);
        wait_cyc(50);
        measure(100, h, r);
        chk(h == 0, "R4 zero high time low", h, 0);

        // R5: high time equal to and above the period
        prog(20, 20);
        wait_cyc(50);
        measure(100, h, r);
        chk(h == 100, "R5 high time equal period", h, 100);
        prog(20, 16'h0100);
        wait_cyc(50);
        measure(100, h, r);
        chk(h == 100, "R5 high time above period", h, 100);

        // R10: periods 0 and 1 run as 2
        prog(0, 1);
        wait_cyc(50);
        measure(20, h, r);
        chk(h == 10, "R10 period 0 high count", h, 10);
        chk(r == 10, "R10 period 0 rising edges", r, 10);
        prog(1, 1);
        wait_cyc(20);
        measure(20, h, r);
        chk(h == 10, "R10 period 1 high count", h, 10);

        // R8: a mid-cycle commit waits for the wrap
        prog(200, 100);
        wait_cyc(20);
        @(negedge clk);
        while (pwm_out) @(negedge clk);
        while (!pwm_out) @(negedge clk);
        wait_cyc(3);
        prog(4, 2);
        measure(60, h, r);
        chk(h == 60, "R8 old high phase completes", h, 60);
        wait_cyc(300);
        measure(40, h, r);
        chk(h == 20, "R8 new values after wrap", h, 20);
        chk(r == 10, "R8 new period after wrap", r, 10);

        // R11: enable low freezes the output
        prog(9, 4);
        wait_cyc(30);
        en_mode = 1;
        wait_cyc(3);
        measure(50, h, r);
        chk((h == 0 || h == 50) && r == 0, "R11 output frozen", h, 0);

        // R11: irregular enable, checked against the model each cycle
        en_mode = 2;
        prog(7, 3);
        wait_cyc(400);
        prog(300, 5);
        wait_cyc(200);
        prog(3, 2);
        wait_cyc(800);
        en_mode = 0;
        wait_cyc(20);

        done = 1'b1;
        finish_run();
    end

endmodule